// File: doc/BRIEF.md
# Two-Strobe Program Sequencer with Equality Branch

This block produces instruction addresses for a small nibble-wide machine. It keeps a program counter and drives it straight to an instruction store. It also holds an instruction register that feeds the execution unit. Two strobes pace the work. The fetch strobe copies the word the store returns for the current address into the instruction register. The execute strobe commits the latched word and moves the counter on.

Most opcodes advance the counter by one, and it wraps back to zero after the last address. The unconditional jump always loads the counter with the low bits of the instruction's address field. The conditional jump loads that target only when the execution unit reports an equality flag. That flag means the register named in the instruction's B field matches register 3. When the flag is clear, the conditional jump increments like any other opcode. Because the counter moves only on the execute strobe, the store address stays steady while a fetch is in progress.

The instruction word is 16 bits. The opcode is in bits [15:12], the address field A in bits [11:4] and the B field in bits [3:0]. The execution unit decodes the B field itself.

Top module: `prog_sequencer`

## Requirements
- R1: A synchronous active-high reset sets `pc_o` to 0 and `ir_o` to 16'h3000, the no-operation word with opcode 0011. This holds even when strobes are active in the same cycle.
- R2: On a clock edge with `fetch_stb` high, `ir_o` takes the value of `instr_i`. Without `fetch_stb`, `ir_o` holds its value.
- R3: `pc_o` changes only on an edge with `exec_stb` high. `fetch_stb` alone never moves it.
- R4: Executing an ordinary opcode (0000 to 1010) sets `pc_o` to its previous value plus one.
- R5: Incrementing from 63 gives 0.
- R6: Executing opcode 1100 loads `pc_o` with `ir_o[9:4]`, which is A[5:0]. It ignores A[7:6] and `eq_i`.
- R7: Executing opcode 1110 with `eq_i` high loads `pc_o` with `ir_o[9:4]`.
- R8: Executing opcode 1110 with `eq_i` low increments `pc_o`.
- R9: An execute strobe with no fetch since the previous execute runs the same latched instruction again.
- R10: When both strobes are high on one edge, the counter acts on the instruction latched before that edge, and `ir_o` takes the new word.
- R11: Executing one of the unused opcodes 1011, 1101 or 1111 increments `pc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_stb | input | 1 | Latch `instr_i` into the instruction register |
| exec_stb | input | 1 | Commit the latched instruction and update the counter |
| instr_i | input | 16 | Instruction word read from the store at `pc_o` |
| eq_i | input | 1 | Equality flag from the execution unit (selected register equals register 3) |
| pc_o | output | 6 | Registered program counter, used as the store address |
| ir_o | output | 16 | Registered instruction for the execution unit |

## Verification
Directed sequences cover the following cases, each of which separates a load from an increment:
- a jump whose A[7:6] bits are set,
- a conditional jump taken once with the flag clear and then again with it set, without a fresh fetch,
- an unused opcode,
- an increment from address 63,
- an edge where both strobes are high, which separates "old instruction" from "new instruction" semantics,
- a reset asserted together with both strobes.

Random stretches then mix strobe combinations, opcodes and flag values. They expose any counter movement on a fetch-only edge, and any register update missing on a strobe edge.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OPC_NOP = 4'b0011;
  localparam logic [OP_W-1:0] OPC_JMP = 4'b1100;
  localparam logic [OP_W-1:0] OPC_JEQ = 4'b1110;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_LOAD = 2'd2
  } pc_act_e;

endpackage

// File: rtl/pseq_instr_latch.sv
module pseq_instr_latch #(
  parameter int               WORD_W   = 16,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [WORD_W-1:0] word_d,
  output logic [WORD_W-1:0] word_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= IDLE_WORD;
    end else if (load_en) begin
      word_q <= word_d;
    end
  end

  AST_IR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(word_q)); // R2
  AST_IR_CAPTURES: assert property (@(posedge clk) disable iff (rst)
    load_en |=> word_q == $past(word_d)); // R2

endmodule

// File: rtl/pseq_branch_unit.sv
module pseq_branch_unit
  import pseq_pkg::*;
(
  input  logic            go,
  input  logic [OP_W-1:0] opcode,
  input  logic            eq_flag,
  output pc_act_e         act
);

  always_comb begin
    act = PC_HOLD;
    if (go) begin
      unique case (opcode)
        OPC_JMP: act = PC_LOAD;
        OPC_JEQ: act = eq_flag ? PC_LOAD : PC_STEP;
        default: act = PC_STEP;
      endcase
    end
  end

endmodule

// File: rtl/pseq_pc_reg.sv
module pseq_pc_reg
  import pseq_pkg::*;
#(
  parameter int PC_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  pc_act_e         act,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q
);

  localparam logic [PC_W-1:0] PC_LAST = '1;
  localparam logic [PC_W-1:0] PC_ONE  = PC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      unique case (act)
        PC_STEP: pc_q <= pc_q + PC_ONE;
        PC_LOAD: pc_q <= target;
        default: pc_q <= pc_q;
      endcase
    end
  end

  AST_PC_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (act == PC_STEP && pc_q == PC_LAST) |=> pc_q == '0); // R5
  AST_PC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (act == PC_HOLD) |=> $stable(pc_q)); // R3

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import pseq_pkg::*;
#(
  parameter int PC_W  = 6,
  parameter int A_W   = 8,
  parameter int B_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fetch_stb,
  input  logic                      exec_stb,
  input  logic [OP_W+A_W+B_W-1:0]   instr_i,
  input  logic                      eq_i,
  output logic [PC_W-1:0]           pc_o,
  output logic [OP_W+A_W+B_W-1:0]   ir_o
);

  localparam int WORD_W = OP_W + A_W + B_W;
  localparam int OP_LSB = A_W + B_W;
  localparam int A_LSB  = B_W;
  localparam logic [WORD_W-1:0] NOP_WORD = {OPC_NOP, {(A_W + B_W){1'b0}}};

  logic [OP_W-1:0] cur_op;
  logic [PC_W-1:0] jump_tgt;
  pc_act_e         pc_act;

  assign cur_op   = ir_o[OP_LSB +: OP_W];
  assign jump_tgt = ir_o[A_LSB +: PC_W];

  pseq_instr_latch #(
    .WORD_W   (WORD_W),
    .IDLE_WORD(NOP_WORD)
  ) u_latch (
    .clk    (clk),
    .rst    (rst),
    .load_en(fetch_stb),
    .word_d (instr_i),
    .word_q (ir_o)
  );

  pseq_branch_unit u_branch (
    .go     (exec_stb),
    .opcode (cur_op),
    .eq_flag(eq_i),
    .act    (pc_act)
  );

  pseq_pc_reg #(
    .PC_W(PC_W)
  ) u_pc (
    .clk   (clk),
    .rst   (rst),
    .act   (pc_act),
    .target(jump_tgt),
    .pc_q  (pc_o)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && ir_o == NOP_WORD)); // R1
  AST_NO_EXEC_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !exec_stb |=> $stable(pc_o)); // R3
  AST_JMP_LOADS: assert property (@(posedge clk) disable iff (rst)
    (exec_stb && ir_o[OP_LSB +: OP_W] == OPC_JMP)
      |=> pc_o == $past(ir_o[A_LSB +: PC_W])); // R6
  AST_JEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (exec_stb && eq_i && ir_o[OP_LSB +: OP_W] == OPC_JEQ)
      |=> pc_o == $past(ir_o[A_LSB +: PC_W])); // R7
  AST_JEQ_MISS: assert property (@(posedge clk) disable iff (rst)
    (exec_stb && !eq_i && ir_o[OP_LSB +: OP_W] == OPC_JEQ)
      |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R8

endmodule

// File: tb/prog_sequencer_tb_top.sv
module prog_sequencer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_stb = 1'b0;
  logic        exec_stb = 1'b0;
  logic [15:0] instr_i = 16'h0000;
  logic        eq_i = 1'b0;
  logic [5:0]  pc_o;
  logic [15:0] ir_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [5:0]  exp_pc = 6'd0;
  logic [15:0] exp_ir = 16'h3000;

  always #5 clk = ~clk;

  prog_sequencer dut_i (
    .clk(clk), .rst(rst), .fetch_stb(fetch_stb), .exec_stb(exec_stb),
    .instr_i(instr_i), .eq_i(eq_i), .pc_o(pc_o), .ir_o(ir_o)
  );

  function automatic logic [5:0] model_pc(logic [5:0] pc, logic [15:0] ir,
                                          logic eq, logic ex);
    if (!ex) return pc;
    if (ir[15:12] == 4'b1100) return ir[9:4];
    if (ir[15:12] == 4'b1110 && eq) return ir[9:4];
    return pc + 6'd1;
  endfunction

  function automatic string pc_tag(logic [5:0] pc, logic [15:0] ir,
                                   logic eq, logic ex);
    if (!ex) return "R3";
    if (ir[15:12] == 4'b1100) return "R6";
    if (ir[15:12] == 4'b1110) return eq ? "R7" : "R8";
    if (pc == 6'd63) return "R5";
    if (ir[15:12] == 4'b1011 || ir[15:12] == 4'b1101 || ir[15:12] == 4'b1111)
      return "R11";
    return "R4";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Drives one cycle at the falling edge and compares after the next rising edge.
  task automatic step(logic f, logic e, logic [15:0] w, logic q, string note);
    string t;
    t = (note != "") ? note : pc_tag(exp_pc, exp_ir, q, e);
    fetch_stb = f; exec_stb = e; instr_i = w; eq_i = q;
    exp_pc = model_pc(exp_pc, exp_ir, q, e);
    if (f) exp_ir = w;
    @(posedge clk);
    @(negedge clk);
    check(t, {10'd0, pc_o}, {10'd0, exp_pc});
    check("R2", ir_o, exp_ir);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", {10'd0, pc_o}, 16'd0);
    check("R1", ir_o, 16'h3000);
    rst = 1'b0;

    step(1, 0, 16'h1234, 0, "R3");   // fetch alone keeps pc
    step(0, 1, 16'hFFFF, 0, "R4");   // ordinary opcode increments
    step(0, 1, 16'hFFFF, 0, "R9");   // re-execute without fetch
    step(1, 0, 16'hCFF0, 0, "");     // JMP with A=FF
    step(0, 1, 16'h0000, 0, "R6");   // target 63, A[7:6] ignored
    step(1, 0, 16'h3000, 1, "");
    step(0, 1, 16'h0000, 1, "R5");   // wrap 63 -> 0
    step(1, 0, 16'hE2A1, 0, "");
    step(0, 1, 16'h0000, 0, "R8");   // JEQ not taken
    step(0, 1, 16'h0000, 1, "R7");   // same JEQ, taken -> 42 (R9)
    step(1, 0, 16'hCC50, 0, "");
    step(0, 1, 16'h0000, 0, "R6");   // target 5 with flag low
    step(1, 0, 16'hB000, 0, "");
    step(0, 1, 16'h0000, 0, "R11");  // unused opcode -> 6
    step(1, 0, 16'hD000, 0, "");
    step(0, 1, 16'h0000, 1, "R11");  // -> 7
    step(1, 0, 16'hF000, 0, "");
    step(0, 1, 16'h0000, 1, "R11");  // -> 8
    step(1, 1, 16'hCC10, 0, "R10");  // old word (F000) increments -> 9
    step(0, 1, 16'h0000, 0, "R10");  // new word jumps -> 1

    rst = 1'b1;
    fetch_stb = 1'b1; exec_stb = 1'b1; instr_i = 16'hC3F0;
    @(posedge clk);
    @(negedge clk);
    check("R1", {10'd0, pc_o}, 16'd0);
    check("R1", ir_o, 16'h3000);
    rst = 1'b0;
    exp_pc = 6'd0;
    exp_ir = 16'h3000;

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w;
      w = $urandom();
      if (($urandom() % 4) == 0) w[15:12] = 4'b1100;
      else if (($urandom() % 4) == 0) w[15:12] = 4'b1110;
      step(1'($urandom()), 1'($urandom()), w, 1'($urandom()), "");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule